// File: doc/BRIEF.md
# Binary-to-Stochastic and Stochastic-to-Binary Converter Pair

This block moves numbers between ordinary k-bit binary form and unipolar stochastic form, where a value is carried as the fraction of 1s in a serial bit-stream. Each of several encoders compares its binary input against a k-bit pseudo-random word once per clock. It drives a 1 whenever the random word is strictly below the input, so the stream's density of 1s is value/2^k. A single decoder counts the 1s on a serial input over a frame of exactly 2^k clocks. At the end of the frame it presents the total as a (k+1)-bit estimate and pulses a done flag.

The random words come from maximal-length shift registers that have been extended with one extra state, so their period is exactly 2^k. Over any 2^k consecutive cycles each such register visits every k-bit word once, including zero. A mode input chooses between two sources for the encoders. In one mode every encoder uses its own register, each with a distinct seed, which gives uncorrelated streams. In the other mode all encoders compare against the first encoder's register, which gives maximally correlated streams. A start pulse reseeds all registers and opens a new decoder frame, so that encoding and counting line up cycle for cycle.

Top module: `sc_converter_pair`

## Requirements
- R1: In the 2^k cycles that follow the clock edge that samples start_i, each encoder stream carries exactly as many 1s as its binary input value.
- R2: An encoder whose value is 0 outputs 0 in every cycle.
- R3: On the 2^k-th clock edge after the edge that sampled start_i, count_o takes the number of 1s sampled on stream_i at the 1st through 2^k-th edges after that start edge.
- R4: count_o is k+1 bits wide, and a frame of all 1s yields exactly 2^k.
- R5: done_o is 1 for exactly one cycle, namely the cycle that follows the edge that loads count_o, and it is 0 in every other cycle.
- R6: The frame count depends only on how many 1s arrive, not on the cycles in which they arrive.
- R7: With share_i = 1, every encoder uses the same random word, so in every cycle a stream with a smaller or equal value being 1 implies that a stream with a larger or equal value is 1.
- R8: With share_i = 0, encoders given equal values produce streams that differ in at least one cycle of a frame, because their random sources are seeded differently.
- R9: After reset, count_o is 0 and done_o is 0.
- R10: A start_i pulse during a running frame abandons that frame. The next done_o comes 2^k cycles after the new start, and its count covers only the samples taken after the new start.
- R11: Between frames, count_o holds its last value and done_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Reseed all random sources and open a decoder frame |
| share_i | input | 1 | 1: all encoders use one random source; 0: each encoder uses its own |
| value_i | input | NUM_ENC*WIDTH | Binary inputs; encoder j uses bits [j*WIDTH +: WIDTH] |
| stream_o | output | NUM_ENC | Stochastic output stream of each encoder |
| stream_i | input | 1 | Stochastic stream to be counted |
| count_o | output | WIDTH+1 | Number of 1s in the last finished frame |
| done_o | output | 1 | One-cycle pulse when count_o is updated |

## Verification
The encoders are driven with the extreme values 0 and 2^k-1, with a mid-range pair, and with equal values under both source modes. The extremes show whether the comparator and the zero-inclusive random sequence give exact counts. The equal pair tells shared sources from independent ones, and the ordered pair checks the nesting of correlated streams. The decoder is also fed bench patterns directly: all ones to cover the overflow into bit k, and two patterns with the same number of 1s placed differently to show that position does not matter. A restart in the middle of a frame confirms that stale samples are dropped. A cycle-accurate behavioural model checks count_o and done_o on every clock throughout.

// File: rtl/sc_conv_pkg.sv
package sc_conv_pkg;

   localparam int MIN_W = 3;
   localparam int MAX_W = 12;

   // Feedback tap mask (bit t-1 set for tap t) of a primitive polynomial;
   // the top bit is always part of the mask.
   function automatic logic [15:0] tap_mask(input int w);
      logic [15:0] m;
      case (w)
         3:       m = 16'h0006;
         4:       m = 16'h000C;
         5:       m = 16'h0014;
         6:       m = 16'h0030;
         7:       m = 16'h0060;
         8:       m = 16'h00B8;
         9:       m = 16'h0110;
         10:      m = 16'h0240;
         11:      m = 16'h0500;
         12:      m = 16'h0829;
         default: m = 16'h0000;
      endcase
      return m;
   endfunction

   // Start state of source idx; the extended sequence contains zero,
   // so any value is a legal seed.
   function automatic logic [15:0] seed_for(input int w, input int idx, input int step);
      int s;
      s = (1 + idx * step) % (1 << w);
      return 16'(s);
   endfunction

endpackage

// File: rtl/sc_debruijn_lfsr.sv
module sc_debruijn_lfsr #(
   parameter int               WIDTH = 5,
   parameter logic [WIDTH-1:0] SEED  = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   output logic [WIDTH-1:0] state_o
);

   localparam logic [15:0]      MASK_FULL = sc_conv_pkg::tap_mask(WIDTH);
   localparam logic [WIDTH-1:0] MASK      = MASK_FULL[WIDTH-1:0];

   if (WIDTH < sc_conv_pkg::MIN_W || WIDTH > sc_conv_pkg::MAX_W) begin : g_bad_width
      $error("sc_debruijn_lfsr: WIDTH out of supported range");
   end

   logic [WIDTH-1:0] state_q;
   logic             lin_fb;
   logic             zero_fix;
   logic             fb;

   // Plain feedback, then the zero-state insertion: when all bits below
   // the top are zero the feedback is inverted, so 100..0 -> 000..0 -> 00..01.
   assign lin_fb   = ^(state_q & MASK);
   assign zero_fix = (state_q[WIDTH-2:0] == '0);
   assign fb       = lin_fb ^ zero_fix;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      state_q <= SEED;
      else if (load_i) state_q <= SEED;
      else             state_q <= {state_q[WIDTH-2:0], fb};
   end

   assign state_o = state_q;

   // R1: period 2^k with every word once, so the register never stalls
   a_r1_never_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> state_q != $past(state_q));

endmodule

// File: rtl/sc_cmp_encoder.sv
module sc_cmp_encoder #(
   parameter int WIDTH = 5
) (
   input  logic [WIDTH-1:0] rnd_i,
   input  logic [WIDTH-1:0] value_i,
   output logic             bit_o
);

   // Strict less-than: value 0 never fires, value 2^k-1 misses one word.
   assign bit_o = (rnd_i < value_i);

endmodule

// File: rtl/sc_frame_counter.sv
module sc_frame_counter #(
   parameter int WIDTH = 5
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic           bit_i,
   output logic [WIDTH:0] count_o,
   output logic           done_o
);

   localparam int           FRAME_LEN = 1 << WIDTH;
   localparam logic [WIDTH:0] FRAME   = (WIDTH+1)'(FRAME_LEN);

   logic           running_q;
   logic [WIDTH:0] cyc_q;
   logic [WIDTH:0] ones_q;
   logic [WIDTH:0] ones_n;
   logic [WIDTH:0] cyc_n;
   logic [WIDTH:0] count_q;
   logic           done_q;

   assign ones_n = ones_q + {{WIDTH{1'b0}}, bit_i};
   assign cyc_n  = cyc_q + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running_q <= 1'b0;
         cyc_q     <= '0;
         ones_q    <= '0;
         count_q   <= '0;
         done_q    <= 1'b0;
      end else if (start_i) begin
         running_q <= 1'b1;
         cyc_q     <= '0;
         ones_q    <= '0;
         done_q    <= 1'b0;
      end else if (running_q) begin
         ones_q <= ones_n;
         cyc_q  <= cyc_n;
         if (cyc_n == FRAME) begin
            count_q   <= ones_n;
            done_q    <= 1'b1;
            running_q <= 1'b0;
         end else begin
            done_q <= 1'b0;
         end
      end else begin
         done_q <= 1'b0;
      end
   end

   assign count_o = count_q;
   assign done_o  = done_q;

   // R5: done is a single-cycle pulse
   a_r5_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R4: a frame can never report more than 2^k ones
   a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count_q <= FRAME);

   // R10: a start always suppresses done in the following cycle
   a_r10_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> !done_q);

   // R11: the reported count only moves together with done
   a_r11_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !done_q |-> $stable(count_q) || $past(start_i) || $past(running_q));

endmodule

// File: rtl/sc_converter_pair.sv
module sc_converter_pair #(
   parameter int WIDTH     = 5,
   parameter int NUM_ENC   = 2,
   parameter int SEED_STEP = 11
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     share_i,
   input  logic [NUM_ENC*WIDTH-1:0] value_i,
   output logic [NUM_ENC-1:0]       stream_o,
   input  logic                     stream_i,
   output logic [WIDTH:0]           count_o,
   output logic                     done_o
);

   if (WIDTH < sc_conv_pkg::MIN_W || WIDTH > sc_conv_pkg::MAX_W) begin : g_bad_width
      $error("sc_converter_pair: WIDTH out of supported range");
   end
   if (NUM_ENC < 1) begin : g_bad_count
      $error("sc_converter_pair: NUM_ENC must be at least 1");
   end
   if (SEED_STEP % 2 == 0) begin : g_bad_step
      $error("sc_converter_pair: SEED_STEP must be odd so seeds stay distinct");
   end

   logic [WIDTH-1:0] rnd   [NUM_ENC];
   logic [WIDTH-1:0] rnd_u [NUM_ENC];
   logic [WIDTH-1:0] val   [NUM_ENC];

   for (genvar j = 0; j < NUM_ENC; j++) begin : g_enc
      localparam logic [15:0] SEED_FULL = sc_conv_pkg::seed_for(WIDTH, j, SEED_STEP);

      sc_debruijn_lfsr #(
         .WIDTH (WIDTH),
         .SEED  (SEED_FULL[WIDTH-1:0])
      ) u_src (
         .clk     (clk),
         .rst_n   (rst_n),
         .load_i  (start_i),
         .state_o (rnd[j])
      );

      assign val[j]   = value_i[j*WIDTH +: WIDTH];
      assign rnd_u[j] = share_i ? rnd[0] : rnd[j];

      sc_cmp_encoder #(
         .WIDTH (WIDTH)
      ) u_cmp (
         .rnd_i   (rnd_u[j]),
         .value_i (val[j]),
         .bit_o   (stream_o[j])
      );

      // R2: a zero input never produces a 1
      a_r2_zero_silent: assert property (@(posedge clk) disable iff (!rst_n)
         (val[j] == '0) |-> !stream_o[j]);
   end

   for (genvar j = 0; j + 1 < NUM_ENC; j++) begin : g_order
      // R7: shared source gives nested streams
      a_r7_shared_up: assert property (@(posedge clk) disable iff (!rst_n)
         share_i && (val[j] <= val[j+1]) && stream_o[j] |-> stream_o[j+1]);
      a_r7_shared_down: assert property (@(posedge clk) disable iff (!rst_n)
         share_i && (val[j+1] <= val[j]) && stream_o[j+1] |-> stream_o[j]);
   end

   sc_frame_counter #(
      .WIDTH (WIDTH)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .bit_i   (stream_i),
      .count_o (count_o),
      .done_o  (done_o)
   );

endmodule

// File: tb/tb_sc_converter_pair.sv
module tb_sc_converter_pair;

   localparam int W  = 5;
   localparam int N  = 2;
   localparam int FR = 1 << W;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic           share = 1'b0;
   logic [N*W-1:0] vals = '0;
   logic [N-1:0]   so;
   logic           si;
   logic [W:0]     cnt;
   logic           done;
   logic           loop_sel = 1'b1;
   logic           pat_bit = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   assign si = loop_sel ? so[0] : pat_bit;

   always #5 clk = ~clk;

   sc_converter_pair #(.WIDTH(W), .NUM_ENC(N), .SEED_STEP(11)) dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .share_i(share),
      .value_i(vals), .stream_o(so), .stream_i(si),
      .count_o(cnt), .done_o(done)
   );

   // behavioural reference of the counting side
   bit         m_run = 0;
   int         m_ones = 0;
   int         m_cyc = 0;
   logic [W:0] m_cnt = '0;
   bit         m_done = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_cnt = '0; m_done = 0;
      end else begin
         m_done = 0;
         if (start) begin
            m_run = 1; m_ones = 0; m_cyc = 0;
         end else if (m_run) begin
            m_ones += int'(si);
            m_cyc++;
            if (m_cyc == FR) begin
               m_cnt  = (W+1)'(m_ones);
               m_done = 1;
               m_run  = 0;
            end
         end
      end
   end

   // R3 R5 R9 R11: compare every cycle
   always @(negedge clk) begin
      n_cmp++;
      if (done !== m_done || cnt !== m_cnt) begin
         n_bad++;
         $display("FAIL R3/R5/R11 cycle: count=%0d done=%0d expected count=%0d done=%0d",
                  cnt, done, m_cnt, m_done);
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the frame's last edge
   task automatic frame(input int v0, input int v1, input bit sh, input bit lp,
                        input logic [FR-1:0] pat,
                        output int o0, output int o1, output bit differ, output bit order_bad);
      o0 = 0; o1 = 0; differ = 0; order_bad = 0;
      share = sh; loop_sel = lp;
      vals = {v1[W-1:0], v0[W-1:0]};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int m = 0; m < FR; m++) begin
         pat_bit = pat[m];
         o0 += int'(so[0]);
         o1 += int'(so[1]);
         if (so[0] != so[1]) differ = 1;
         if (v0 <= v1 && so[0] && !so[1]) order_bad = 1;
         if (v1 <= v0 && so[1] && !so[0]) order_bad = 1;
         @(negedge clk);
      end
      chk(done === 1'b1, "R5 done at end of frame", int'(done), 1);
   endtask

   int o0, o1;
   bit df, ob;

   initial begin
      repeat (3) @(negedge clk);
      chk(cnt === '0, "R9 reset count", int'(cnt), 0);
      chk(done === 1'b0, "R9 reset done", int'(done), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 R2: extremes, looped back into the counter (R3)
      frame(0, 31, 0, 1, '0, o0, o1, df, ob);
      chk(o0 == 0, "R2 zero value stream", o0, 0);
      chk(o1 == 31, "R1 max value ones", o1, 31);
      chk(cnt == 0, "R3 count of zero stream", int'(cnt), 0);

      frame(31, 0, 0, 1, '0, o0, o1, df, ob);
      chk(o0 == 31, "R1 max value ones enc0", o0, 31);
      chk(cnt == 31, "R3 count of max stream", int'(cnt), 31);

      // R7: shared, ordered pair
      frame(17, 9, 1, 1, '0, o0, o1, df, ob);
      chk(o0 == 17, "R1 shared enc0 ones", o0, 17);
      chk(o1 == 9, "R1 shared enc1 ones", o1, 9);
      chk(!ob, "R7 nested shared streams", int'(ob), 0);
      chk(cnt == 17, "R3 count mid value", int'(cnt), 17);

      // R8: independent, equal values
      frame(16, 16, 0, 1, '0, o0, o1, df, ob);
      chk(df, "R8 independent streams differ", int'(df), 1);
      chk(o0 == 16 && o1 == 16, "R1 equal values ones", o0 + o1, 32);

      // R7: shared, equal values -> identical
      frame(16, 16, 1, 1, '0, o0, o1, df, ob);
      chk(!df, "R7 shared equal streams identical", int'(df), 0);

      // R4: all ones into the counter
      frame(0, 0, 0, 0, '1, o0, o1, df, ob);
      chk(cnt == 32, "R4 all ones count", int'(cnt), 32);

      // R6: same number of ones, different positions
      frame(0, 0, 0, 0, 32'h0000_00FF, o0, o1, df, ob);
      chk(cnt == 8, "R6 clustered ones", int'(cnt), 8);
      frame(0, 0, 0, 0, 32'h1111_1111, o0, o1, df, ob);
      chk(cnt == 8, "R6 spread ones", int'(cnt), 8);

      // R10: restart inside a running frame (first frame sees ones only)
      loop_sel = 1'b0; pat_bit = 1'b1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      chk(done === 1'b0, "R10 no done before restart", int'(done), 0);
      frame(5, 3, 0, 1, '0, o0, o1, df, ob);
      chk(cnt == 5, "R10 count after restart", int'(cnt), 5);

      // R11: hold between frames
      repeat (6) @(negedge clk);
      chk(cnt == 5, "R11 count holds", int'(cnt), 5);
      chk(done === 1'b0, "R11 done stays low", int'(done), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule